// File: doc/BRIEF.md
# Dual-Order Burst Address Sequencer

This block produces the two low address bits of a four-beat burst into a synchronous SRAM. A qualified load strobe comes from the address-strobe logic upstream. When it is high, the block takes the two low bits of the incoming external address as the burst start offset. On each later clock where the active-low advance input is low, the burst moves forward one beat. While advance is high, the burst is suspended in place. The upper address register, the memory array and the data path sit outside this block.

A static mode input picks the burst order. Low selects the sequential (linear) order. High selects the interleaved order, which is the default that board straps should provide when the pin is left unused. Internally a beat state machine counts beats 0 to 3. The emitted offset is the start offset combined with that count: added modulo 4 in linear order, XORed in interleaved order.

The state machine has four states: `BEAT_FIRST`, `BEAT_SECOND`, `BEAT_THIRD` and `BEAT_FOURTH`. Its transitions are:
- **load**: any state goes to `BEAT_FIRST`.
- **step**: each state goes to the next, and `BEAT_FOURTH` wraps to `BEAT_FIRST`.
- **hold**: the state is kept.

Top module: `burst_addr_seq`

## Requirements
- R1: While synchronous active-high reset `rst` is sampled high, the start offset and beat state clear, so the next cycle shows `offset_o` = 00 and `last_beat_o` = 0.
- R2: When `load_i` is sampled high, the cycle after the edge shows `offset_o` equal to the sampled `start_i` and `last_beat_o` = 0 (beat 0).
- R3: A load takes priority over an advance sampled in the same edge: `offset_o` shows the new start, not an advanced value.
- R4: With `mode_i` = 0, the beat k (k = 0..3) offset is (start + k) mod 4. For example, a start of 01 yields 01,10,11,00.
- R5: With `mode_i` = 1, the beat k offset is start XOR k. For example, a start of 01 yields 01,00,11,10 and a start of 11 yields 11,10,01,00.
- R6: When `adv_n_i` is sampled high and `load_i` is low, `offset_o` and `last_beat_o` keep their values (burst suspend).
- R7: An advance from the fourth beat wraps back to beat 0, so `offset_o` returns to the start offset.
- R8: `last_beat_o` is 1 exactly while the burst is on its fourth beat (k = 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Qualified strobe: a new external address is being captured |
| start_i | input | 2 | Two low bits of the external address |
| adv_n_i | input | 1 | Advance one beat, active low |
| mode_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| offset_o | output | 2 | Current two-bit burst offset |
| last_beat_o | output | 1 | High on the fourth beat |

## Verification
The embedded assertions check the following on every cycle:
- a load always lands on beat 0 with the sampled start on `offset_o`, including when advance is also low;
- a suspend leaves the beat state and the outputs unchanged;
- a linear step adds one modulo 4;
- `last_beat_o` only rises after an advance;
- an advance from the last beat returns to the start offset.

The full interleaved sequence for every start value, the reset state, and suspends placed in the middle of a burst are shown only by the directed scenarios, which compare the outputs against per-beat expected values.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    localparam int OFS_W = 2;
    localparam int BEATS = 1 << OFS_W;

    typedef enum logic [OFS_W-1:0] {
        BEAT_FIRST  = 2'd0,
        BEAT_SECOND = 2'd1,
        BEAT_THIRD  = 2'd2,
        BEAT_FOURTH = 2'd3
    } beat_state_t;

    typedef enum logic {
        ORDER_LINEAR     = 1'b0,
        ORDER_INTERLEAVE = 1'b1
    } burst_order_t;

endpackage

// File: rtl/bseq_start_reg.sv
module bseq_start_reg #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] start_d,
    output logic [W-1:0] start_q
);

    always_ff @(posedge clk) begin
        if (rst)
            start_q <= '0;
        else if (load)
            start_q <= start_d;
    end

    // R2: the captured start only changes on a load
    assert_start_held_R2: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(start_q));

endmodule

// File: rtl/bseq_beat_fsm.sv
module bseq_beat_fsm
    import bseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             adv_n,
    output logic [OFS_W-1:0] beat_cnt,
    output logic             last
);

    beat_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= BEAT_FIRST;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d = BEAT_FIRST;
        end else if (!adv_n) begin
            unique case (state_q)
                BEAT_FIRST:  state_d = BEAT_SECOND;
                BEAT_SECOND: state_d = BEAT_THIRD;
                BEAT_THIRD:  state_d = BEAT_FOURTH;
                BEAT_FOURTH: state_d = BEAT_FIRST;
                default:     state_d = BEAT_FIRST;
            endcase
        end
    end

    always_comb begin
        beat_cnt = state_q;
        last     = 1'b0;
        unique case (state_q)
            BEAT_FIRST:  beat_cnt = 2'd0;
            BEAT_SECOND: beat_cnt = 2'd1;
            BEAT_THIRD:  beat_cnt = 2'd2;
            BEAT_FOURTH: begin
                beat_cnt = 2'd3;
                last     = 1'b1;
            end
            default: beat_cnt = 2'd0;
        endcase
    end

    // R3: a load always lands on the first beat, even with advance low
    assert_load_first_R3: assert property (@(posedge clk) disable iff (rst)
        load |=> (beat_cnt == 2'd0) && !last);

    // R6: suspend keeps the beat
    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!load && adv_n) |=> $stable(beat_cnt) && $stable(last));

endmodule

// File: rtl/bseq_offset_map.sv
module bseq_offset_map
    import bseq_pkg::*;
(
    input  logic             mode,
    input  logic [OFS_W-1:0] start,
    input  logic [OFS_W-1:0] beat,
    output logic [OFS_W-1:0] offset
);

    logic [OFS_W-1:0] lin_ofs;
    logic [OFS_W-1:0] ilv_ofs;

    always_comb begin
        lin_ofs = start + beat;
        ilv_ofs = start ^ beat;
        unique case (burst_order_t'(mode))
            ORDER_LINEAR:     offset = lin_ofs;
            ORDER_INTERLEAVE: offset = ilv_ofs;
            default:          offset = ilv_ofs;
        endcase
    end

    // R5: interleaved offset never differs from start outside the beat bits
    always_comb begin
        if (mode == 1'b1)
            assert_ilv_map_R5: assert ((offset ^ start) == beat);
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import bseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load_i,
    input  logic [1:0] start_i,
    input  logic       adv_n_i,
    input  logic       mode_i,
    output logic [1:0] offset_o,
    output logic       last_beat_o
);

    logic [OFS_W-1:0] start_q;
    logic [OFS_W-1:0] beat_cnt;

    bseq_start_reg #(.W(OFS_W)) u_start (
        .clk     (clk),
        .rst     (rst),
        .load    (load_i),
        .start_d (start_i),
        .start_q (start_q)
    );

    bseq_beat_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .load     (load_i),
        .adv_n    (adv_n_i),
        .beat_cnt (beat_cnt),
        .last     (last_beat_o)
    );

    bseq_offset_map u_map (
        .mode   (mode_i),
        .start  (start_q),
        .beat   (beat_cnt),
        .offset (offset_o)
    );

    // R2: the sampled start appears on the next cycle
    assert_load_offset_R2: assert property (@(posedge clk) disable iff (rst)
        load_i |=> offset_o == $past(start_i));

    // R4: a linear step adds one modulo 4 when mode is steady
    assert_lin_step_R4: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !adv_n_i && !mode_i) |=>
            (mode_i != $past(mode_i)) || (offset_o == 2'($past(offset_o) + 2'd1)));

    // R7: stepping past the last beat returns to the start offset
    assert_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (last_beat_o && !load_i && !adv_n_i) |=> (offset_o == start_q) && !last_beat_o);

    // R8: the last-beat flag only rises after an advance
    assert_last_rise_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(last_beat_o) |-> $past(!load_i && !adv_n_i));

endmodule

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;

    localparam time PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load_i = 1'b0;
    logic [1:0] start_i = 2'b00;
    logic       adv_n_i = 1'b1;
    logic       mode_i = 1'b1;
    logic [1:0] offset_o;
    logic       last_beat_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    burst_addr_seq i_burst_addr_seq (
        .clk         (clk),
        .rst         (rst),
        .load_i      (load_i),
        .start_i     (start_i),
        .adv_n_i     (adv_n_i),
        .mode_i      (mode_i),
        .offset_o    (offset_o),
        .last_beat_o (last_beat_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // drive on the falling edge, sample a quarter period after the rise
    task automatic cyc(input logic ld, input logic [1:0] st, input logic advn);
        @(negedge clk);
        load_i  = ld;
        start_i = st;
        adv_n_i = advn;
        @(posedge clk);
        #(PERIOD/4);
    endtask

    function automatic int expect_ofs(input logic md, input int s, input int k);
        if (md) return s ^ k;
        return (s + k) % 4;
    endfunction

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #(PERIOD/4);
        chk("R1 offset", offset_o, 0);
        chk("R1 last", last_beat_o, 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_order(input logic md, input string req);
        @(negedge clk);
        mode_i = md;
        for (int s = 0; s < 4; s++) begin
            cyc(1'b1, 2'(s), 1'b1);
            chk("R2 load", offset_o, s);
            chk({req, " beat0"}, offset_o, expect_ofs(md, s, 0));
            for (int k = 1; k < 4; k++) begin
                cyc(1'b0, 2'(~s), 1'b0);
                chk(req, offset_o, expect_ofs(md, s, k));
                chk("R8 last", last_beat_o, (k == 3) ? 1 : 0);
            end
            cyc(1'b0, 2'b00, 1'b0);
            chk("R7 wrap", offset_o, s);
            chk("R8 clear", last_beat_o, 0);
        end
    endtask

    task automatic t_suspend();
        @(negedge clk);
        mode_i = 1'b0;
        cyc(1'b1, 2'b10, 1'b1);
        cyc(1'b0, 2'b01, 1'b0);
        chk("R4 step", offset_o, 3);
        for (int i = 0; i < 3; i++) begin
            cyc(1'b0, 2'(i), 1'b1);
            chk("R6 hold", offset_o, 3);
            chk("R6 last", last_beat_o, 0);
        end
        cyc(1'b0, 2'b00, 1'b0);
        cyc(1'b0, 2'b00, 1'b0);
        chk("R8 last", last_beat_o, 1);
        cyc(1'b0, 2'b00, 1'b1);
        chk("R6 hold last", last_beat_o, 1);
        chk("R6 hold ofs", offset_o, 1);
    endtask

    task automatic t_priority();
        @(negedge clk);
        mode_i = 1'b1;
        cyc(1'b1, 2'b01, 1'b1);
        cyc(1'b0, 2'b00, 1'b0);
        cyc(1'b0, 2'b00, 1'b0);
        chk("R5 beat2", offset_o, 3);
        cyc(1'b1, 2'b10, 1'b0);
        chk("R3 new start", offset_o, 2);
        chk("R3 beat0", last_beat_o, 0);
        cyc(1'b0, 2'b00, 1'b0);
        chk("R5 after load", offset_o, 3);
    endtask

    initial begin
        rst = 1'b1;
        repeat (2) @(posedge clk);
        t_reset();
        t_order(1'b0, "R4 linear");
        t_order(1'b1, "R5 interleaved");
        t_suspend();
        t_priority();
        t_reset();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule